// File: doc/BRIEF.md
# Synchronous Burst Cache SRAM

This block is a single-port synchronous memory for a processor cache. It has a 32-bit write path, a flow-through read path and a separate enable for the pad drivers of the shared data bus. On the rising clock edge it captures the word address, three chip-select inputs and the access controls. A two-bit burst sequencer then produces the low address bits for the remaining words of a four-word line.

An access starts from one of two active-low strobes. One comes from the processor and one comes from the cache controller. The processor strobe is blocked while the primary select is inactive, and it never writes on its starting edge. The controller strobe takes its write controls on its starting edge. Once a burst is open, an active-low step input advances it by one word per clock. Writes can cover the whole word or single byte lanes. An output-enable input and a sleep input gate the drivers at once, without waiting for a clock. While sleep is high, new accesses are refused and the stored contents are kept.

Top module: `burst_cache_sram`

## Requirements
- R1: After a synchronous reset the data drivers are off (`rd_data_oe` = 0, `rd_data` = 0) until an access is started.
- R2: If `cpu_strobe_n` is low, `sel_n` is low, `sel_hi` is high and `sel2_n` is low at a rising edge, a burst opens at `addr`. The word is driven on `rd_data` in the same cycle after that edge (flow-through). The write inputs are not acted on at that edge.
- R3: If `cpu_strobe_n` is low while `sel_n` is high, the processor strobe has no effect. If `cpu_strobe_n` is low with `sel_n` low but `sel_hi` low or `sel2_n` high, the block deselects and its drivers go off.
- R4: When `ctl_strobe_n` is low and the processor strobe is not acting, all three selects active load `addr` and apply the write controls at that edge. Any inactive select deselects the block.
- R5: With both strobes inactive and a burst open, `step_n` low moves to the next word of the burst. `step_n` high keeps the same word, so each later word of a burst costs exactly one clock.
- R6: With `burst_order` = 0 sampled at the burst's start, word k (k = 0..3) uses low address bits (start + k) mod 4.
- R7: With `burst_order` = 1 sampled at the burst's start, word k uses low address bits start XOR k.
- R8: `gw_n` low writes all four byte lanes of `wr_data`, whatever `lane_we_n` and `lane_n` hold.
- R9: With `gw_n` high and `lane_we_n` low, byte lane i (bits 8i+7..8i) is written only where `lane_n[i]` is low. With both `gw_n` and `lane_we_n` high, nothing is written and `lane_n` has no effect.
- R10: `oe_n` high turns the drivers off at once, without a clock edge. `oe_n` low restores the addressed word at once.
- R11: `sleep` high turns the drivers off at once. While it is high, strobes and writes are ignored and the stored words are kept. After it falls, the block stays deselected until a new strobe.
- R12: In the cycle after an edge that performed a write, the drivers are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address taken when a burst starts |
| burst_order | input | 1 | 1 = XOR sequence, 0 = wrapping increment; taken at burst start |
| cpu_strobe_n | input | 1 | Processor start strobe, active low |
| ctl_strobe_n | input | 1 | Controller start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Primary select, active low |
| sel_hi | input | 1 | Bank select, active high |
| sel2_n | input | 1 | Bank select, active low |
| gw_n | input | 1 | Whole-word write, active low |
| lane_we_n | input | 1 | Byte-lane write qualifier, active low |
| lane_n | input | DATA_W/8 | Per-lane write selects, active low |
| wr_data | input | DATA_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| rd_data | output | DATA_W | Read data, zero when not driven |
| rd_data_oe | output | 1 | Drive enable for the data bus pads |

## Verification
The bench builds the block with `ADDR_W` = 5 and `DATA_W` = 32, which gives a 32-word array. The whole array is first filled through controller-strobe bursts. The random phase then lands repeatedly on the same lines, so byte-lane merges, wrap-around within a line and reads after sleep all hit words whose contents the bench model already knows. With 32-bit words there are four byte lanes, so every `lane_n` pattern is reachable.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int CNT_W = 2;

    typedef enum logic [2:0] {
        ACC_NONE    = 3'd0,
        ACC_DESEL   = 3'd1,
        ACC_START_P = 3'd2,
        ACC_START_C = 3'd3,
        ACC_CONT    = 3'd4
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      step;
        logic      wr;
    } acc_cmd_t;

    function automatic logic [CNT_W-1:0] burst_low(
        input logic [CNT_W-1:0] base,
        input logic [CNT_W-1:0] cnt,
        input logic             xor_order
    );
        return xor_order ? (base ^ cnt) : (base + cnt);
    endfunction

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
    import burst_sram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             rst,
    input  logic             sleep,
    input  logic             active,
    input  logic             cpu_strobe_n,
    input  logic             ctl_strobe_n,
    input  logic             step_n,
    input  logic             sel_n,
    input  logic             sel_hi,
    input  logic             sel2_n,
    input  logic             gw_n,
    input  logic             lane_we_n,
    input  logic [LANES-1:0] lane_n,
    output acc_cmd_t         cmd,
    output logic [LANES-1:0] lane_mask
);

    logic sel_ok;
    logic cpu_req;
    logic ctl_req;

    always_comb begin
        sel_ok  = !sel_n && sel_hi && !sel2_n;
        cpu_req = !cpu_strobe_n && !sel_n;
        ctl_req = !ctl_strobe_n && !cpu_req;

        if (!gw_n)
            lane_mask = '1;
        else if (!lane_we_n)
            lane_mask = ~lane_n;
        else
            lane_mask = '0;

        cmd.kind = ACC_NONE;
        cmd.step = 1'b0;
        cmd.wr   = 1'b0;

        if (rst) begin
            cmd.kind = ACC_NONE;
        end else if (sleep) begin
            cmd.kind = ACC_DESEL;
        end else if (cpu_req) begin
            cmd.kind = sel_ok ? ACC_START_P : ACC_DESEL;
        end else if (ctl_req) begin
            if (sel_ok) begin
                cmd.kind = ACC_START_C;
                cmd.wr   = |lane_mask;
            end else begin
                cmd.kind = ACC_DESEL;
            end
        end else if (active) begin
            cmd.kind = ACC_CONT;
            cmd.step = !step_n;
            cmd.wr   = |lane_mask;
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_cmd_t          cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst_order,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              sel_q,
    output logic              wr_q
);

    localparam int HI_W = ADDR_W - CNT_W;

    logic [HI_W-1:0]  hi_q;
    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             order_q;

    always_comb begin
        cnt_nx   = cnt_q + CNT_W'(cmd.step);
        cur_addr = {hi_q, burst_low(base_q, cnt_q, order_q)};
        case (cmd.kind)
            ACC_START_P, ACC_START_C: acc_addr = addr;
            ACC_CONT:                 acc_addr = {hi_q, burst_low(base_q, cnt_nx, order_q)};
            default:                  acc_addr = cur_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q    <= '0;
            base_q  <= '0;
            cnt_q   <= '0;
            order_q <= 1'b0;
            sel_q   <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            case (cmd.kind)
                ACC_START_P, ACC_START_C: begin
                    hi_q    <= addr[ADDR_W-1:CNT_W];
                    base_q  <= addr[CNT_W-1:0];
                    cnt_q   <= '0;
                    order_q <= burst_order;
                    sel_q   <= 1'b1;
                    wr_q    <= cmd.wr;
                end
                ACC_CONT: begin
                    cnt_q <= cnt_nx;
                    wr_q  <= cmd.wr;
                end
                ACC_DESEL: begin
                    sel_q <= 1'b0;
                    wr_q  <= 1'b0;
                end
                default: begin
                    wr_q <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/byte_lane_ram.sv
module byte_lane_ram #(
    parameter int ADDR_W = 7,
    parameter int LANES  = 4
) (
    input  logic               clk,
    input  logic               we,
    input  logic [LANES-1:0]   mask,
    input  logic [ADDR_W-1:0]  wa,
    input  logic [ADDR_W-1:0]  ra,
    input  logic [LANES*8-1:0] wd,
    output logic [LANES*8-1:0] rd
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && mask[g])
                cells[wa] <= wd[g*8 +: 8];
        end

        assign rd[g*8 +: 8] = cells[ra];
    end

endmodule

// File: rtl/burst_cache_sram.sv
module burst_cache_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                burst_order,
    input  logic                cpu_strobe_n,
    input  logic                ctl_strobe_n,
    input  logic                step_n,
    input  logic                sel_n,
    input  logic                sel_hi,
    input  logic                sel2_n,
    input  logic                gw_n,
    input  logic                lane_we_n,
    input  logic [DATA_W/8-1:0] lane_n,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                oe_n,
    input  logic                sleep,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_data_oe
);

    localparam int LANES = DATA_W / 8;

    acc_cmd_t          cmd;
    logic [LANES-1:0]  lane_mask;
    logic [ADDR_W-1:0] acc_addr;
    logic [ADDR_W-1:0] cur_addr;
    logic              sel_q;
    logic              wr_q;
    logic [DATA_W-1:0] array_q;

    sram_cmd_decode #(.LANES(LANES)) u_decode (
        .rst          (rst),
        .sleep        (sleep),
        .active       (sel_q),
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .step_n       (step_n),
        .sel_n        (sel_n),
        .sel_hi       (sel_hi),
        .sel2_n       (sel2_n),
        .gw_n         (gw_n),
        .lane_we_n    (lane_we_n),
        .lane_n       (lane_n),
        .cmd          (cmd),
        .lane_mask    (lane_mask)
    );

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .addr        (addr),
        .burst_order (burst_order),
        .acc_addr    (acc_addr),
        .cur_addr    (cur_addr),
        .sel_q       (sel_q),
        .wr_q        (wr_q)
    );

    byte_lane_ram #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ram (
        .clk  (clk),
        .we   (cmd.wr),
        .mask (lane_mask),
        .wa   (acc_addr),
        .ra   (cur_addr),
        .wd   (wr_data),
        .rd   (array_q)
    );

    always_comb begin
        rd_data_oe = sel_q && !wr_q && !oe_n && !sleep;
        rd_data    = rd_data_oe ? array_q : '0;
    end

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_strobe_n,
    input logic              ctl_strobe_n,
    input logic              step_n,
    input logic              sel_n,
    input logic              sel_hi,
    input logic              sel2_n,
    input logic              gw_n,
    input logic              lane_we_n,
    input logic              oe_n,
    input logic              sleep,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_data_oe
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !rd_data_oe);

    // R10
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst) oe_n |-> !rd_data_oe);

    // R11
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst) sleep |-> !rd_data_oe);

    // R3
    cpu_desel_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_strobe_n && !sel_n && (!sel_hi || sel2_n)) |=> !rd_data_oe);

    // R12
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep && cpu_strobe_n && !ctl_strobe_n && !gw_n && !sel_n && sel_hi && !sel2_n)
        |=> !rd_data_oe);

    // R5
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data_oe && cpu_strobe_n && ctl_strobe_n && step_n && gw_n && lane_we_n && !sleep)
        |=> (oe_n || sleep || (rd_data_oe && $stable(rd_data))));

endmodule

bind burst_cache_sram burst_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .step_n       (step_n),
    .sel_n        (sel_n),
    .sel_hi       (sel_hi),
    .sel2_n       (sel2_n),
    .gw_n         (gw_n),
    .lane_we_n    (lane_we_n),
    .oe_n         (oe_n),
    .sleep        (sleep),
    .rd_data      (rd_data),
    .rd_data_oe   (rd_data_oe)
);

// File: tb/burst_cache_sram_tb.sv
module burst_cache_sram_tb;

    localparam int AW    = 5;
    localparam int DW    = 32;
    localparam int LN    = DW / 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          burst_order;
    logic          cpu_strobe_n, ctl_strobe_n, step_n;
    logic          sel_n, sel_hi, sel2_n;
    logic          gw_n, lane_we_n;
    logic [LN-1:0] lane_n;
    logic [DW-1:0] wr_data;
    logic          oe_n, sleep;
    logic [DW-1:0] rd_data;
    logic          rd_data_oe;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] exp_mem [DEPTH];
    logic          m_sel, m_wr, m_order;
    logic [AW-3:0] m_hi;
    logic [1:0]    m_base, m_cnt;

    always #2 clk = ~clk;

    burst_cache_sram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .burst_order(burst_order),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .step_n(step_n),
        .sel_n(sel_n), .sel_hi(sel_hi), .sel2_n(sel2_n),
        .gw_n(gw_n), .lane_we_n(lane_we_n), .lane_n(lane_n), .wr_data(wr_data),
        .oe_n(oe_n), .sleep(sleep), .rd_data(rd_data), .rd_data_oe(rd_data_oe)
    );

    // R6 / R7: burst word offset from the requirement text
    function automatic logic [1:0] word_low(input logic [1:0] b, input logic [1:0] k, input logic x);
        return x ? (b ^ k) : (b + k);
    endfunction

    function automatic logic [AW-1:0] model_addr();
        return {m_hi, word_low(m_base, m_cnt, m_order)};
    endfunction

    // R8 / R9: which lanes a write touches
    function automatic logic [LN-1:0] model_mask();
        if (!gw_n) return '1;
        if (!lane_we_n) return ~lane_n;
        return '0;
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [LN-1:0] m);
        for (int i = 0; i < LN; i++)
            if (m[i]) exp_mem[a][i*8 +: 8] = wr_data[i*8 +: 8];
        m_wr = (m != '0);
    endtask

    task automatic model_step();
        logic ok;
        ok = !sel_n && sel_hi && !sel2_n;
        if (rst) begin
            m_sel = 0; m_wr = 0; m_hi = '0; m_base = '0; m_cnt = '0; m_order = 0;
        end else if (sleep) begin
            m_sel = 0; m_wr = 0;
        end else if (!cpu_strobe_n && !sel_n) begin
            if (ok) begin
                m_sel = 1; m_wr = 0; {m_hi, m_base} = addr; m_cnt = '0; m_order = burst_order;
            end else begin
                m_sel = 0; m_wr = 0;
            end
        end else if (!ctl_strobe_n) begin
            if (ok) begin
                m_sel = 1; {m_hi, m_base} = addr; m_cnt = '0; m_order = burst_order;
                model_write(addr, model_mask());
            end else begin
                m_sel = 0; m_wr = 0;
            end
        end else if (m_sel) begin
            if (!step_n) m_cnt = m_cnt + 2'd1;
            model_write(model_addr(), model_mask());
        end else begin
            m_wr = 0;
        end
    endtask

    task automatic check_out(input string req);
        logic          e_oe;
        logic [DW-1:0] e_d;
        e_oe = m_sel && !m_wr && !oe_n && !sleep;
        e_d  = e_oe ? exp_mem[model_addr()] : '0;
        checks++;
        if (rd_data_oe !== e_oe || rd_data !== e_d) begin
            errors++;
            $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h", req, rd_data_oe, rd_data, e_oe, e_d);
        end
    endtask

    task automatic cyc(input string req);
        model_step();
        @(posedge clk);
        #1;
        check_out(req);
    endtask

    task automatic idle_in();
        cpu_strobe_n = 1; ctl_strobe_n = 1; step_n = 1;
        sel_n = 0; sel_hi = 1; sel2_n = 0;
        gw_n = 1; lane_we_n = 1; lane_n = '1;
        oe_n = 0; sleep = 0;
    endtask

    task automatic cpu_start(input logic [AW-1:0] a, input logic ord, input string req);
        idle_in(); addr = a; burst_order = ord; cpu_strobe_n = 0;
        cyc(req);
        idle_in();
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        idle_in(); addr = '0; burst_order = 0; wr_data = '0; rst = 1;
        cyc("R1"); cyc("R1");
        rst = 0;
        cyc("R1");

        // Fill: controller-strobe bursts writing whole words (R4, R5, R8)
        for (int line = 0; line < DEPTH / 4; line++) begin
            idle_in(); addr = AW'(line * 4); burst_order = 0; ctl_strobe_n = 0; gw_n = 0;
            wr_data = $urandom; cyc("R4");
            for (int k = 1; k < 4; k++) begin
                idle_in(); gw_n = 0; step_n = 0; wr_data = $urandom; cyc("R12");
            end
        end

        // Linear burst from offset 1 (R2, R5, R6)
        cpu_start(AW'(5), 0, "R2");
        for (int k = 1; k < 4; k++) begin step_n = 0; cyc("R6"); end
        step_n = 1; cyc("R5"); cyc("R5");

        // Interleaved burst from offset 1 (R7)
        cpu_start(AW'(9), 1, "R7");
        for (int k = 1; k < 5; k++) begin step_n = 0; cyc("R7"); end

        // Processor strobe ignores write inputs on its start edge (R2)
        idle_in(); addr = AW'(3); burst_order = 0; cpu_strobe_n = 0; gw_n = 0; wr_data = 32'hdead_beef;
        cyc("R2");
        idle_in(); cyc("R2");

        // Byte-lane write at addr 2 lanes 0 and 2 (R9), then read back
        idle_in(); addr = AW'(2); ctl_strobe_n = 0; lane_we_n = 0; lane_n = 4'b1010; wr_data = 32'h1122_3344;
        cyc("R9");
        cpu_start(AW'(2), 0, "R9");
        // lane selects with no qualifier: no write (R9)
        idle_in(); lane_n = 4'b0000; wr_data = 32'hffff_ffff; cyc("R9"); cyc("R9");

        // Whole-word write overrides lane selects (R8)
        idle_in(); addr = AW'(2); ctl_strobe_n = 0; gw_n = 0; lane_we_n = 0; lane_n = '1; wr_data = 32'hcafe_f00d;
        cyc("R8");
        cpu_start(AW'(2), 0, "R8");

        // Select qualification (R3, R4)
        cpu_start(AW'(12), 0, "R3");
        idle_in(); cpu_strobe_n = 0; sel_n = 1; addr = AW'(20); step_n = 0; cyc("R3");
        idle_in(); cpu_strobe_n = 0; sel_hi = 0; addr = AW'(20); cyc("R3");
        cpu_start(AW'(12), 0, "R3");
        idle_in(); cpu_strobe_n = 0; sel2_n = 1; cyc("R3");
        cpu_start(AW'(13), 0, "R4");
        idle_in(); ctl_strobe_n = 0; sel2_n = 1; gw_n = 0; wr_data = 32'h0bad_0bad; addr = AW'(13); cyc("R4");
        cpu_start(AW'(13), 0, "R4");

        // Asynchronous output enable (R10)
        oe_n = 1; #1 check_out("R10");
        oe_n = 0; #1 check_out("R10");
        @(posedge clk); #1;

        // Sleep (R11)
        sleep = 1; #1 check_out("R11");
        ctl_strobe_n = 0; gw_n = 0; addr = AW'(13); wr_data = 32'h5151_5151; cyc("R11");
        idle_in(); sleep = 1; cpu_strobe_n = 0; addr = AW'(14); cyc("R11");
        idle_in(); cyc("R11");
        cpu_start(AW'(13), 0, "R11");

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            idle_in();
            r = $urandom % 10;
            addr = AW'($urandom); burst_order = 1'($urandom);
            if (r < 2) cpu_strobe_n = 0;
            else if (r < 4) ctl_strobe_n = 0;
            step_n = ($urandom % 3) == 0;
            gw_n = ($urandom % 5) != 0;
            lane_we_n = ($urandom % 3) != 0;
            lane_n = LN'($urandom);
            wr_data = $urandom;
            oe_n = ($urandom % 10) == 0;
            sleep = ($urandom % 20) == 0;
            if (($urandom % 6) == 0) begin
                sel_n = 1'($urandom); sel_hi = 1'($urandom); sel2_n = 1'($urandom);
            end
            cyc("R5");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule